// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends a single command byte from a host controller to a PS/2-style device over an open-drain clock/data pair. A one-cycle start strobe with the byte on `cmd` begins the transfer. The block first holds the clock line low to inhibit the device. It then releases the clock while pulling data low, which requests a send and also serves as the start bit. From that point the device generates the clock. After each falling edge of the device clock, the host presents the next bit: eight data bits least significant first, an odd parity bit, and a released (high) stop bit. On the eleventh falling edge the host samples the device's acknowledge.

All timing is counted in microsecond ticks derived from the system clock by a divider. The minimum inhibit time, the hold delay after a falling edge, the wait for the device to start clocking and the limit on the whole frame are all parameters. Both pad inputs pass through a two-flop synchronizer and a stability filter before any edge is detected. Both outputs are pull-enables: 1 pulls the wire low and 0 releases it, so the pad never drives a high level. The state machine moves through these states:

- IDLE
- INHIBIT (clock pulled low)
- REQUEST (clock released, data low, waiting for the first device edge)
- SHIFT (presenting bits)
- ACK (waiting for the acknowledge edge)

Its transitions are:

- start-accept: IDLE→INHIBIT
- inhibit-elapsed: INHIBIT→REQUEST
- first-edge: REQUEST→SHIFT
- start-timeout: REQUEST→IDLE
- stop-presented: SHIFT→ACK
- frame-timeout: SHIFT or ACK→IDLE
- ack-sampled: ACK→IDLE

Top module: `ps2_cmd_tx`

## Requirements
- R1: After reset, and after every reported result, `busy` is 0 and both `ps2_clk_pull` and `ps2_dat_pull` are 0 (lines released).
- R2: A `start` seen while idle raises `busy` on the next cycle and pulls the clock low. The clock stays pulled for at least INHIBIT_US×TICK_DIV cycles, and data stays released during this time.
- R3: When the inhibit ends, the clock is released in the same cycle that data is pulled low, and data stays low until the first device falling edge (start bit = 0).
- R4: After device falling edges 1 to 10, the data line carries D0..D7 (least significant first), then parity, then stop = 1 (released). Each value is present before the next rising edge. Data does not change within HOLD_US µs of a falling edge.
- R5: The parity bit makes the count of ones over the eight data bits and parity odd.
- R6: At the 11th device falling edge, the filtered data line is sampled. Low gives a one-cycle `done`; high gives a one-cycle `ack_err`.
- R7: If no device falling edge arrives within START_TO_US µs of the start being accepted, `timeout` pulses once and both lines are released.
- R8: If the 11th falling edge does not arrive within FRAME_TO_US µs of the first one, `timeout` pulses once and both lines are released.
- R9: Each transfer ends with exactly one of `done`, `ack_err` or `timeout`, and `busy` is 0 in that cycle. A `start` while busy neither aborts the transfer nor alters the byte sent.
- R10: A `start` given in the same cycle that a result pulse is shown is accepted, and a new transfer begins.
- R11: A low pulse on the clock input shorter than FILT_LEN cycles is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer of `cmd` (taken only when idle) |
| cmd | input | 8 | Command byte, captured with an accepted start |
| ps2_clk_in | input | 1 | Level of the clock wire |
| ps2_dat_in | input | 1 | Level of the data wire |
| ps2_clk_pull | output | 1 | 1 pulls the clock wire low, 0 releases it |
| ps2_dat_pull | output | 1 | 1 pulls the data wire low, 0 releases it |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse: frame sent and acknowledged |
| ack_err | output | 1 | One-cycle pulse: device did not acknowledge |
| timeout | output | 1 | One-cycle pulse: device did not start or finish in time |

## Verification
Two events can fall in the same cycle: a result pulse and the acceptance of the next start. Because the result is registered together with the return to IDLE, a start in that cycle is already taken. The bench provokes this by watching for `done` at the falling clock edge and raising `start` right there. It then judges that `busy` and the clock pull are both set one cycle later, and that the second byte arrives intact at the device model. A second pairing is a start strobe landing mid-frame. It is judged by the frame still carrying the first byte and by `busy` remaining high.

// File: rtl/ps2_cmd_tx_pkg.sv
package ps2_cmd_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_INHIBIT = 3'd1,
        ST_REQUEST = 3'd2,
        ST_SHIFT   = 3'd3,
        ST_ACK     = 3'd4
    } tx_state_e;

    // Bits after the start bit, index 0..9: data LSB first, odd parity, stop.
    // Upper positions padded with released level.
    function automatic logic [15:0] build_frame(input logic [7:0] b);
        return {6'h3F, 1'b1, ~^b, b};
    endfunction

endpackage

// File: rtl/ps2_cmd_tx_tick.sv
module ps2_cmd_tx_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tick <= 1'b0;
                else        tick <= 1'b1;
            end
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt  <= '0;
                    tick <= 1'b0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt  <= cnt + 1'b1;
                    tick <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ps2_cmd_tx_filt.sv
module ps2_cmd_tx_filt #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            dout <= 1'b1;
            cnt  <= '0;
        end else begin
            s1 <= din;
            s2 <= s1;
            if (s2 == dout) begin
                cnt <= '0;
            end else if (cnt == CW'(LEN - 1)) begin
                dout <= s2;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ps2_cmd_tx_uscnt.sv
module ps2_cmd_tx_uscnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (clr)                cnt <= '0;
        else if (tick && cnt != '1)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx
    import ps2_cmd_tx_pkg::*;
#(
    parameter int TICK_DIV    = 50,
    parameter int INHIBIT_US  = 100,
    parameter int START_TO_US = 15000,
    parameter int FRAME_TO_US = 2000,
    parameter int HOLD_US     = 5,
    parameter int FILT_LEN    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] cmd,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    output logic       ps2_clk_pull,
    output logic       ps2_dat_pull,
    output logic       busy,
    output logic       done,
    output logic       ack_err,
    output logic       timeout
);
    localparam int M1 = (START_TO_US > FRAME_TO_US) ? START_TO_US : FRAME_TO_US;
    localparam int M2 = (M1 > INHIBIT_US) ? M1 : INHIBIT_US;
    localparam int M3 = (M2 > HOLD_US) ? M2 : HOLD_US;
    localparam int TW = $clog2(M3 + 3);
    localparam logic [TW-1:0] INH_LIM  = TW'(INHIBIT_US);
    localparam logic [TW-1:0] STO_LIM  = TW'(START_TO_US);
    localparam logic [TW-1:0] FTO_LIM  = TW'(FRAME_TO_US);
    localparam logic [TW-1:0] HOLD_LIM = TW'(HOLD_US);
    localparam logic [3:0]    LAST_IDX = 4'd9;

    tx_state_e state, nxt;

    logic          us_tick;
    logic [1:0]    pad_raw, pad_flt;
    logic          clk_f, dat_f, clk_f_q, fall;
    logic [7:0]    cmd_q;
    logic [15:0]   frame;
    logic [3:0]    idx;
    logic          pend;
    logic [TW-1:0] t_req, t_frm, t_hold;
    logic          go, inh_done, req_to, frm_to, apply;

    // ---------------- timebase and input conditioning ----------------
    ps2_cmd_tx_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(us_tick)
    );

    assign pad_raw = {ps2_dat_in, ps2_clk_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        ps2_cmd_tx_filt #(.LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .din(pad_raw[g]), .dout(pad_flt[g])
        );
    end

    assign clk_f = pad_flt[0];
    assign dat_f = pad_flt[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_f_q <= 1'b1;
        else        clk_f_q <= clk_f;
    end

    assign fall = clk_f_q & ~clk_f;

    // ---------------- microsecond timers ----------------
    ps2_cmd_tx_uscnt #(.W(TW)) u_treq (
        .clk(clk), .rst_n(rst_n), .tick(us_tick),
        .clr(state == ST_IDLE), .cnt(t_req)
    );

    ps2_cmd_tx_uscnt #(.W(TW)) u_tfrm (
        .clk(clk), .rst_n(rst_n), .tick(us_tick),
        .clr(!(state == ST_SHIFT || state == ST_ACK)), .cnt(t_frm)
    );

    ps2_cmd_tx_uscnt #(.W(TW)) u_thold (
        .clk(clk), .rst_n(rst_n), .tick(us_tick),
        .clr(fall), .cnt(t_hold)
    );

    // ---------------- conditions ----------------
    assign go       = start && (state == ST_IDLE);
    assign inh_done = t_req > INH_LIM;
    assign req_to   = t_req > STO_LIM;
    assign frm_to   = t_frm > FTO_LIM;
    assign apply    = (state == ST_SHIFT) && pend && (t_hold > HOLD_LIM);
    assign frame    = build_frame(cmd_q);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (go) nxt = ST_INHIBIT;
            ST_INHIBIT: if (inh_done) nxt = ST_REQUEST;
            ST_REQUEST: begin
                if (fall)        nxt = ST_SHIFT;
                else if (req_to) nxt = ST_IDLE;
            end
            ST_SHIFT: begin
                if (frm_to)                          nxt = ST_IDLE;
                else if (apply && idx == LAST_IDX)   nxt = ST_ACK;
            end
            ST_ACK: begin
                if (fall || frm_to) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // ---------------- bit sequencing ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            idx   <= '0;
            pend  <= 1'b0;
        end else begin
            if (go) cmd_q <= cmd;
            if (state == ST_IDLE || state == ST_REQUEST) idx <= '0;
            else if (apply)                              idx <= idx + 1'b1;
            if (fall && (state == ST_REQUEST || state == ST_SHIFT)) pend <= 1'b1;
            else if (apply || state == ST_IDLE)                     pend <= 1'b0;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps2_clk_pull <= 1'b0;
            ps2_dat_pull <= 1'b0;
            done         <= 1'b0;
            ack_err      <= 1'b0;
            timeout      <= 1'b0;
        end else begin
            done    <= 1'b0;
            ack_err <= 1'b0;
            timeout <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        ps2_clk_pull <= 1'b1;
                        ps2_dat_pull <= 1'b0;
                    end
                end
                ST_INHIBIT: begin
                    if (inh_done) begin
                        ps2_clk_pull <= 1'b0;
                        ps2_dat_pull <= 1'b1;
                    end
                end
                ST_REQUEST: begin
                    if (!fall && req_to) begin
                        ps2_dat_pull <= 1'b0;
                        timeout      <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (frm_to) begin
                        ps2_dat_pull <= 1'b0;
                        timeout      <= 1'b1;
                    end else if (apply) begin
                        ps2_dat_pull <= ~frame[idx];
                    end
                end
                ST_ACK: begin
                    ps2_dat_pull <= 1'b0;
                    if (fall) begin
                        done    <= ~dat_f;
                        ack_err <= dat_f;
                    end else if (frm_to) begin
                        timeout <= 1'b1;
                    end
                end
                default: begin
                    ps2_clk_pull <= 1'b0;
                    ps2_dat_pull <= 1'b0;
                end
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ps2_cmd_tx_chk.sv
module ps2_cmd_tx_chk #(
    parameter int INHIBIT_US = 100,
    parameter int TICK_DIV   = 50
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic clk_pull,
    input logic dat_pull,
    input logic done,
    input logic ack_err,
    input logic timeout
);
    int unsigned inh_cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        inh_cyc <= 0;
        else if (clk_pull) inh_cyc <= inh_cyc + 1;
        else               inh_cyc <= 0;
    end

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!clk_pull && !dat_pull));

    a_r2_start_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && clk_pull && !dat_pull));

    a_r2_inhibit_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_pull) && busy) |-> (inh_cyc >= INHIBIT_US * TICK_DIV));

    a_r3_request_pulls_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_pull) && busy) |-> dat_pull);

    a_r9_single_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, ack_err, timeout}));

    a_r9_result_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done || ack_err || timeout) |-> !busy);

    a_r9_start_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done || ack_err || timeout));
endmodule

bind ps2_cmd_tx ps2_cmd_tx_chk #(
    .INHIBIT_US(INHIBIT_US),
    .TICK_DIV  (TICK_DIV)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .clk_pull(ps2_clk_pull),
    .dat_pull(ps2_dat_pull),
    .done    (done),
    .ack_err (ack_err),
    .timeout (timeout)
);

// File: tb/sim_ps2_cmd_tx.sv
`timescale 1ns/1ps
module sim_ps2_cmd_tx;
    localparam int TD   = 2;
    localparam int INH  = 20;
    localparam int STO  = 100;
    localparam int FTO  = 250;
    localparam int HOLD = 1;
    localparam int FL   = 2;
    localparam int HALF = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] cmd = 8'h00;
    logic dev_clk_low = 1'b0;
    logic dev_dat_low = 1'b0;
    logic clk_line, dat_line;
    logic ps2_clk_pull, ps2_dat_pull, busy, done, ack_err, timeout;

    int n_run = 0, n_fail = 0;
    int n_done = 0, n_err = 0, n_to = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    assign clk_line = ~(ps2_clk_pull | dev_clk_low);
    assign dat_line = ~(ps2_dat_pull | dev_dat_low);

    ps2_cmd_tx #(
        .TICK_DIV(TD), .INHIBIT_US(INH), .START_TO_US(STO),
        .FRAME_TO_US(FTO), .HOLD_US(HOLD), .FILT_LEN(FL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .ps2_clk_in(clk_line), .ps2_dat_in(dat_line),
        .ps2_clk_pull(ps2_clk_pull), .ps2_dat_pull(ps2_dat_pull),
        .busy(busy), .done(done), .ack_err(ack_err), .timeout(timeout)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (done)    n_done++;
            if (ack_err) n_err++;
            if (timeout) n_to++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<195000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic kick(input logic [7:0] b);
        @(negedge clk);
        cmd = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Device model: frm[0]=start bit, frm[1..10]=bits read on rising edges.
    task automatic dev_frame(input bit do_ack, input int nfall, input bit glitch,
                             output logic [10:0] frm, output int inh, output int hv);
        logic v0;
        frm = '1;
        inh = 0;
        hv  = 0;
        for (int w = 0; w < 100 && !ps2_clk_pull; w++) @(negedge clk);
        while (ps2_clk_pull) begin
            inh++;
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
        frm[0] = dat_line;
        if (glitch) begin
            dev_clk_low = 1'b1;
            @(negedge clk);
            dev_clk_low = 1'b0;
            repeat (6) @(negedge clk);
        end
        for (int k = 1; k <= nfall; k++) begin
            v0 = dat_line;
            dev_clk_low = 1'b1;
            for (int c = 0; c < HALF; c++) begin
                @(negedge clk);
                if (c < HOLD * TD && dat_line !== v0) hv++;
            end
            if (k <= 10) frm[k] = dat_line;
            dev_clk_low = 1'b0;
            if (k == 10 && do_ack) dev_dat_low = 1'b1;
            repeat (HALF) @(negedge clk);
            if (k == 11) dev_dat_low = 1'b0;
        end
        dev_clk_low = 1'b0;
        dev_dat_low = 1'b0;
    endtask

    task automatic wait_any(input int base, input int limit, output int waited);
        waited = 0;
        while ((n_done + n_err + n_to) == base && waited < limit) begin
            @(negedge clk);
            waited++;
        end
    endtask

    initial begin
        logic [10:0] frm;
        int inh, hv, base, w, d0, e0, t0;
        logic [7:0] b;

        repeat (4) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(ps2_clk_pull == 1'b0 && ps2_dat_pull == 1'b0, "R1 lines after reset",
            {ps2_clk_pull, ps2_dat_pull}, 0);
        chk({done, ack_err, timeout} == 3'b000, "R1 no result in reset",
            {done, ack_err, timeout}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && ps2_clk_pull == 1'b0, "R1 idle after release",
            {busy, ps2_clk_pull}, 0);

        // R4 R5 R6 R2 R3: sweep every byte value
        for (int v = 0; v < 256; v++) begin
            b  = 8'(v);
            d0 = n_done;
            base = n_done + n_err + n_to;
            kick(b);
            chk(busy && ps2_clk_pull && !ps2_dat_pull, "R2 inhibit begins",
                {busy, ps2_clk_pull, ps2_dat_pull}, 3'b110);
            dev_frame(1'b1, 11, 1'b0, frm, inh, hv);
            wait_any(base, 50, w);
            chk(inh + 1 >= INH * TD, "R2 inhibit length", inh + 1, INH * TD);
            chk(frm[0] == 1'b0, "R3 start bit", frm[0], 0);
            chk(frm[8:1] == b, "R4 data bits", frm[8:1], b);
            chk(frm[9] == ~^b, "R5 parity", frm[9], ~^b);
            chk(frm[10] == 1'b1, "R4 stop bit", frm[10], 1);
            chk(hv == 0, "R4 hold after fall", hv, 0);
            chk(n_done == d0 + 1 && (n_done + n_err + n_to) == base + 1,
                "R6 done once", n_done - d0, 1);
            chk(!busy && !ps2_clk_pull && !ps2_dat_pull, "R1 released after done",
                {busy, ps2_clk_pull, ps2_dat_pull}, 0);
        end

        // R6: missing acknowledge
        e0 = n_err;
        base = n_done + n_err + n_to;
        kick(8'h3C);
        dev_frame(1'b0, 11, 1'b0, frm, inh, hv);
        wait_any(base, 50, w);
        chk(n_err == e0 + 1 && (n_done + n_err + n_to) == base + 1, "R6 ack error",
            n_err - e0, 1);

        // R7: device never clocks
        t0 = n_to;
        base = n_done + n_err + n_to;
        kick(8'h81);
        wait_any(base, 1000, w);
        chk(n_to == t0 + 1 && (n_done + n_err + n_to) == base + 1, "R7 start timeout",
            n_to - t0, 1);
        chk(w >= 2 * STO - 4 && w <= 2 * STO + 8, "R7 timeout latency", w, 2 * STO);
        @(negedge clk);
        chk(!busy && !ps2_clk_pull && !ps2_dat_pull, "R7 lines released",
            {busy, ps2_clk_pull, ps2_dat_pull}, 0);

        // R8: device stops after three clocks
        t0 = n_to;
        base = n_done + n_err + n_to;
        kick(8'h42);
        dev_frame(1'b1, 3, 1'b0, frm, inh, hv);
        wait_any(base, 1200, w);
        chk(n_to == t0 + 1 && (n_done + n_err + n_to) == base + 1, "R8 frame timeout",
            n_to - t0, 1);
        @(negedge clk);
        chk(!busy && !ps2_clk_pull && !ps2_dat_pull, "R8 lines released",
            {busy, ps2_clk_pull, ps2_dat_pull}, 0);

        // R9: start mid-frame is ignored
        d0 = n_done;
        base = n_done + n_err + n_to;
        kick(8'h5A);
        fork
            dev_frame(1'b1, 11, 1'b0, frm, inh, hv);
            begin
                repeat (150) @(negedge clk);
                cmd = 8'hFF;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk(busy == 1'b1, "R9 busy kept", busy, 1);
            end
        join
        wait_any(base, 50, w);
        chk(frm[8:1] == 8'h5A, "R9 byte unaltered", frm[8:1], 8'h5A);
        chk(n_done == d0 + 1, "R9 single result", n_done - d0, 1);

        // R10: start in the cycle the result is shown
        d0 = n_done;
        kick(8'hA5);
        fork
            dev_frame(1'b1, 11, 1'b0, frm, inh, hv);
            begin
                for (int c = 0; c < 2000 && !done; c++) @(negedge clk);
                cmd = 8'hC3;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk(busy && ps2_clk_pull, "R10 back-to-back accept",
                    {busy, ps2_clk_pull}, 3);
            end
        join
        chk(frm[8:1] == 8'hA5, "R10 first byte", frm[8:1], 8'hA5);
        base = n_done + n_err + n_to;
        dev_frame(1'b1, 11, 1'b0, frm, inh, hv);
        wait_any(base, 50, w);
        chk(frm[8:1] == 8'hC3, "R10 second byte", frm[8:1], 8'hC3);
        chk(n_done == d0 + 2, "R10 two results", n_done - d0, 2);

        // R11: short clock glitch before the first real edge
        d0 = n_done;
        base = n_done + n_err + n_to;
        kick(8'h96);
        dev_frame(1'b1, 11, 1'b1, frm, inh, hv);
        wait_any(base, 50, w);
        chk(frm[8:1] == 8'h96 && frm[10] == 1'b1, "R11 glitch ignored",
            frm[10:1], {1'b1, ~^8'h96, 8'h96});
        chk(n_done == d0 + 1, "R11 done after glitch", n_done - d0, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule